// File: doc/BRIEF.md
# Multiplexed Bus Latch and Memory Decoder

This block is the glue between a microcontroller whose low address byte and data share one port and the memories around it. The processor puts the low address byte on the shared port and pulses the address-latch strobe. The block keeps that byte for the rest of the bus cycle. It also turns the top three address bits into eight active-low block selects, one for each 8K window. From those selects and the processor's code-fetch, read and write strobes it builds the chip enables for four devices:

- a monitor ROM at 0000h–1FFFh, code space only;
- a user ROM at 2000h–3FFFh;
- an 8K RAM at 8000h–9FFFh, which answers both code fetches and data reads;
- a peripheral in block 0 that lives only in data space.

The block is written for an FPGA fabric. Every input is sampled on the rising clock edge, and every output is a register that reflects the inputs of the previous edge. The wider processor clocking and the memory devices stay outside the block.

Block 0 is shared by the monitor ROM and the peripheral, and the strobe type keeps them apart. Address bit 8 picks between the peripheral's internal RAM and its register file, which gives the peripheral a data-space map from 0000h to 0105h.

Top module: `mux_bus_glue`

## Requirements
- R1: When `ale` is 1 at a rising edge, `addr_lo` shows the value of `ad_low` from that edge after the edge.
- R2: When `ale` is 0 at a rising edge, `addr_lo` keeps its previous value.
- R3: After each rising edge out of reset, exactly one bit of `blk_sel_n` is 0. That bit's index equals the value of `addr_blk` (address bits 15:13) sampled at that edge, so bit i selects block i.
- R4: `mon_oe_n` is 0 exactly when the sampled block is 0 and `psen_n` is 0.
- R5: `usr_oe_n` is 0 exactly when the sampled block is 1 and `psen_n` is 0.
- R6: `ram_ce_n` is 0 exactly when the sampled block is 4. `ram_oe_n` is 0 exactly when the block is 4, either `psen_n` or `rd_n` is 0, and `wr_n` is 1.
- R7: `ram_we_n` is 0 exactly when the sampled block is 4 and `wr_n` is 0.
- R8: For the peripheral, `per_rd_n` is 0 exactly when the block is 0, `rd_n` is 0 and `psen_n` is 1. `per_wr_n` is 0 exactly when the block is 0 and `wr_n` is 0. `per_ce_n` is 0 exactly when either of `per_rd_n` or `per_wr_n` is 0.
- R9: `per_regsel` equals the `addr_b8` value sampled at the previous edge. A 1 selects the register file and a 0 selects the peripheral RAM.
- R10: When neither `psen_n` nor `rd_n` is 0 at an edge, all four read enables (`mon_oe_n`, `usr_oe_n`, `ram_oe_n`, `per_rd_n`) are 1 after that edge. At no time is more than one of them 0.
- R11: While `rst` is 1 at an edge, after that edge `addr_lo` is 00h, `blk_sel_n` is FFh, `per_regsel` is 0, and every enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address-latch strobe, active high |
| ad_low | input | 8 | Shared low address / data port |
| addr_blk | input | 3 | Address bits 15:13 |
| addr_b8 | input | 1 | Address bit 8 |
| psen_n | input | 1 | Code-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| addr_lo | output | 8 | Held low address byte |
| blk_sel_n | output | 8 | Active-low 8K block selects |
| mon_oe_n | output | 1 | Monitor ROM enable |
| usr_oe_n | output | 1 | User ROM enable |
| ram_ce_n | output | 1 | RAM chip enable |
| ram_oe_n | output | 1 | RAM output enable |
| ram_we_n | output | 1 | RAM write enable |
| per_ce_n | output | 1 | Peripheral chip enable |
| per_rd_n | output | 1 | Peripheral read strobe |
| per_wr_n | output | 1 | Peripheral write strobe |
| per_regsel | output | 1 | Peripheral RAM/register select |

## Verification
Every output is one register away from the inputs, so a wrong decode or qualification term shows on the ports in the cycle right after the stimulus. The bench therefore checks every output after every applied bus state.

A held address byte that was corrupted stays wrong on `addr_lo` until the next strobe. The bench makes it visible by applying several non-strobe cycles after each capture.

Strobe collisions are driven on purpose, so that a missing priority term appears as two read enables low together:

- code fetch and read together in block 0;
- read and write together in block 4.

// File: rtl/glue_pkg.sv
package glue_pkg;

  // Bus strobes after conversion to active-high form.
  typedef struct packed {
    logic code;   // code fetch
    logic rd;     // data read
    logic wr;     // data write
  } strobe_t;

  function automatic strobe_t to_strobes(input logic psen_n, input logic rd_n,
                                         input logic wr_n);
    strobe_t s;
    s.code = ~psen_n;
    s.rd   = ~rd_n;
    s.wr   = ~wr_n;
    return s;
  endfunction

endpackage

// File: rtl/low_addr_capture.sv
module low_addr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ale) q <= d;
  end

  // R1: capture while the strobe is high
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    ale |=> (q == $past(d)));

  // R2: hold while the strobe is low
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(q));

endmodule

// File: rtl/block_select_dec.sv
module block_select_dec #(
  parameter int BLK_BITS = 3,
  localparam int NBLK = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BLK_BITS-1:0] blk_idx,
  output logic [NBLK-1:0]     sel_n_q
);

  logic [NBLK-1:0] hit;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign hit[i] = (blk_idx == BLK_BITS'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_n_q <= '1;
    else     sel_n_q <= ~hit;
  end

  // R3: never two blocks at once
  p_sel_onehot0_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n_q));

  // R3: the selected bit follows the sampled block number
  p_sel_index_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_n_q[$past(blk_idx)] == 1'b0));

endmodule

// File: rtl/strobe_qualifier.sv
module strobe_qualifier
  import glue_pkg::*;
#(
  parameter int BLK_BITS = 3,
  parameter int MON_BLK  = 0,
  parameter int USR_BLK  = 1,
  parameter int RAM_BLK  = 4,
  parameter int PER_BLK  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BLK_BITS-1:0] blk_idx,
  input  strobe_t             stb,
  input  logic                regsel_in,
  output logic                mon_oe_n,
  output logic                usr_oe_n,
  output logic                ram_ce_n,
  output logic                ram_oe_n,
  output logic                ram_we_n,
  output logic                per_ce_n,
  output logic                per_rd_n,
  output logic                per_wr_n,
  output logic                per_regsel
);

  localparam logic [BLK_BITS-1:0] MON_IDX = BLK_BITS'(MON_BLK);
  localparam logic [BLK_BITS-1:0] USR_IDX = BLK_BITS'(USR_BLK);
  localparam logic [BLK_BITS-1:0] RAM_IDX = BLK_BITS'(RAM_BLK);
  localparam logic [BLK_BITS-1:0] PER_IDX = BLK_BITS'(PER_BLK);

  logic in_mon, in_usr, in_ram, in_per;
  logic mon_d, usr_d, ram_rd_d, ram_wr_d, per_rd_d, per_wr_d;

  assign in_mon = (blk_idx == MON_IDX);
  assign in_usr = (blk_idx == USR_IDX);
  assign in_ram = (blk_idx == RAM_IDX);
  assign in_per = (blk_idx == PER_IDX);

  always_comb begin
    // Code-space ROMs: code-fetch strobe only.
    mon_d    = in_mon & stb.code;
    usr_d    = in_usr & stb.code;
    // Shared RAM: either read-type strobe, masked while a write is active.
    ram_rd_d = in_ram & (stb.code | stb.rd) & ~stb.wr;
    ram_wr_d = in_ram & stb.wr;
    // Data-space peripheral: a code fetch owns the bus, so it blocks reads.
    per_rd_d = in_per & stb.rd & ~stb.code;
    per_wr_d = in_per & stb.wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_oe_n   <= 1'b1;
      usr_oe_n   <= 1'b1;
      ram_ce_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_we_n   <= 1'b1;
      per_ce_n   <= 1'b1;
      per_rd_n   <= 1'b1;
      per_wr_n   <= 1'b1;
      per_regsel <= 1'b0;
    end else begin
      mon_oe_n   <= ~mon_d;
      usr_oe_n   <= ~usr_d;
      ram_ce_n   <= ~in_ram;
      ram_oe_n   <= ~ram_rd_d;
      ram_we_n   <= ~ram_wr_d;
      per_ce_n   <= ~(per_rd_d | per_wr_d);
      per_rd_n   <= ~per_rd_d;
      per_wr_n   <= ~per_wr_d;
      per_regsel <= regsel_in;
    end
  end

  // R4: monitor ROM only for code fetches in its block
  p_mon_on_r4: assert property (@(posedge clk) disable iff (rst)
    (in_mon && stb.code) |=> !mon_oe_n);
  p_mon_off_r4: assert property (@(posedge clk) disable iff (rst)
    !stb.code |=> mon_oe_n);

  // R5: user ROM only for code fetches in its block
  p_usr_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!in_usr || !stb.code) |=> usr_oe_n);

  // R6: RAM output enable needs a read-type strobe in its block
  p_ram_oe_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ram && stb.rd && !stb.wr) |=> !ram_oe_n);

  // R7: RAM write enable follows the write strobe in its block
  p_ram_we_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ram && stb.wr) |=> !ram_we_n);

  // R8: peripheral chip enable covers exactly its read and write strobes
  p_per_ce_r8: assert property (@(posedge clk) disable iff (rst)
    per_ce_n == (per_rd_n & per_wr_n));

  // R10: no read-type strobe leaves every read enable idle
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!stb.code && !stb.rd) |=> (mon_oe_n && usr_oe_n && ram_oe_n && per_rd_n));

  // R10: at most one device drives the data bus
  p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mon_oe_n, ~usr_oe_n, ~ram_oe_n, ~per_rd_n}));

endmodule

// File: rtl/mux_bus_glue.sv
module mux_bus_glue
  import glue_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int BLK_BITS = 3,
  parameter int MON_BLK  = 0,
  parameter int USR_BLK  = 1,
  parameter int RAM_BLK  = 4,
  parameter int PER_BLK  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ale,
  input  logic [LO_W-1:0]          ad_low,
  input  logic [BLK_BITS-1:0]      addr_blk,
  input  logic                     addr_b8,
  input  logic                     psen_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  output logic [LO_W-1:0]          addr_lo,
  output logic [(1<<BLK_BITS)-1:0] blk_sel_n,
  output logic                     mon_oe_n,
  output logic                     usr_oe_n,
  output logic                     ram_ce_n,
  output logic                     ram_oe_n,
  output logic                     ram_we_n,
  output logic                     per_ce_n,
  output logic                     per_rd_n,
  output logic                     per_wr_n,
  output logic                     per_regsel
);

  strobe_t stb;
  assign stb = to_strobes(psen_n, rd_n, wr_n);

  low_addr_capture #(.W(LO_W)) u_lat (
    .clk (clk),
    .rst (rst),
    .ale (ale),
    .d   (ad_low),
    .q   (addr_lo)
  );

  block_select_dec #(.BLK_BITS(BLK_BITS)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .blk_idx (addr_blk),
    .sel_n_q (blk_sel_n)
  );

  strobe_qualifier #(
    .BLK_BITS (BLK_BITS),
    .MON_BLK  (MON_BLK),
    .USR_BLK  (USR_BLK),
    .RAM_BLK  (RAM_BLK),
    .PER_BLK  (PER_BLK)
  ) u_qual (
    .clk        (clk),
    .rst        (rst),
    .blk_idx    (addr_blk),
    .stb        (stb),
    .regsel_in  (addr_b8),
    .mon_oe_n   (mon_oe_n),
    .usr_oe_n   (usr_oe_n),
    .ram_ce_n   (ram_ce_n),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n),
    .per_ce_n   (per_ce_n),
    .per_rd_n   (per_rd_n),
    .per_wr_n   (per_wr_n),
    .per_regsel (per_regsel)
  );

  // R9: the register-select output tracks address bit 8 one edge later
  p_regsel_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (per_regsel == $past(addr_b8)));

  // R6: the RAM chip enable matches its block select line
  p_ram_ce_r6: assert property (@(posedge clk) disable iff (rst)
    ram_ce_n == blk_sel_n[RAM_BLK]);

endmodule

// File: tb/mux_bus_glue_tb_top.sv
module mux_bus_glue_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       ale;
  logic [7:0] ad_low;
  logic [2:0] addr_blk;
  logic       addr_b8;
  logic       psen_n, rd_n, wr_n;
  logic [7:0] addr_lo, blk_sel_n;
  logic       mon_oe_n, usr_oe_n, ram_ce_n, ram_oe_n, ram_we_n;
  logic       per_ce_n, per_rd_n, per_wr_n, per_regsel;

  int   errors = 0;
  int   checks = 0;
  logic [7:0] exp_lo;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  mux_bus_glue dut_i (
    .clk(clk), .rst(rst), .ale(ale), .ad_low(ad_low), .addr_blk(addr_blk),
    .addr_b8(addr_b8), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_lo(addr_lo), .blk_sel_n(blk_sel_n), .mon_oe_n(mon_oe_n),
    .usr_oe_n(usr_oe_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .per_ce_n(per_ce_n), .per_rd_n(per_rd_n),
    .per_wr_n(per_wr_n), .per_regsel(per_regsel)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Expected outputs from the requirements; strobes are active high here.
  task automatic verify(input logic [2:0] b, input logic a8,
                        input logic ps, input logic rd, input logic wr);
    logic per_r, per_w;
    per_r = (b == 3'd0) && rd && !ps;
    per_w = (b == 3'd0) && wr;
    chk("R1/R2", "addr_lo", addr_lo, exp_lo);
    chk("R3", "blk_sel_n", blk_sel_n, ~(8'd1 << b));
    chk("R4", "mon_oe_n", 8'(mon_oe_n), 8'(!((b == 3'd0) && ps)));
    chk("R5", "usr_oe_n", 8'(usr_oe_n), 8'(!((b == 3'd1) && ps)));
    chk("R6", "ram_ce_n", 8'(ram_ce_n), 8'(b != 3'd4));
    chk("R6", "ram_oe_n", 8'(ram_oe_n), 8'(!((b == 3'd4) && (ps || rd) && !wr)));
    chk("R7", "ram_we_n", 8'(ram_we_n), 8'(!((b == 3'd4) && wr)));
    chk("R8", "per_rd_n", 8'(per_rd_n), 8'(!per_r));
    chk("R8", "per_wr_n", 8'(per_wr_n), 8'(!per_w));
    chk("R8", "per_ce_n", 8'(per_ce_n), 8'(!(per_r || per_w)));
    chk("R9", "per_regsel", 8'(per_regsel), 8'(a8));
    chk("R10", "read enables low",
        8'($countones({~mon_oe_n, ~usr_oe_n, ~ram_oe_n, ~per_rd_n}) > 1), 8'd0);
  endtask

  // Apply one bus state at a falling edge, check after the next rising edge.
  task automatic step(input logic [2:0] b, input logic a8, input logic [7:0] lo,
                      input logic l, input logic ps, input logic rd, input logic wr);
    @(negedge clk);
    addr_blk = b; addr_b8 = a8; ad_low = lo; ale = l;
    psen_n = !ps; rd_n = !rd; wr_n = !wr;
    if (l) exp_lo = lo;
    @(negedge clk);
    verify(b, a8, ps, rd, wr);
  endtask

  task automatic t_reset_r11;
    rst = 1'b1; ale = 1'b1; ad_low = 8'h5A; addr_blk = 3'd4; addr_b8 = 1'b1;
    psen_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "addr_lo", addr_lo, 8'h00);
    chk("R11", "blk_sel_n", blk_sel_n, 8'hFF);
    chk("R11", "enables", 8'({mon_oe_n, usr_oe_n, ram_ce_n, ram_oe_n, ram_we_n,
                              per_ce_n, per_rd_n, per_wr_n}), 8'hFF);
    chk("R11", "per_regsel", 8'(per_regsel), 8'd0);
    ale = 1'b0; psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rst = 1'b0;
    exp_lo = 8'h00;
  endtask

  task automatic t_latch_r1_r2;
    step(3'd2, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);
    step(3'd2, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0);
    step(3'd2, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    step(3'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd2, 1'b1, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0);
    step(3'd2, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_decode_r3;
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 8'(i * 17), 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) step(3'(i), 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_code_fetch_r4_r5;
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ram_r6_r7;
    step(3'd4, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0);  // code fetch
    step(3'd4, 1'b0, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0);  // data read
    step(3'd4, 1'b0, 8'h12, 1'b1, 1'b0, 1'b0, 1'b1);  // write
    step(3'd4, 1'b0, 8'h13, 1'b1, 1'b0, 1'b1, 1'b1);  // read+write clash
    step(3'd5, 1'b0, 8'h14, 1'b1, 1'b0, 1'b1, 1'b1);  // outside the window
  endtask

  task automatic t_periph_r8_r9;
    step(3'd0, 1'b0, 8'h20, 1'b1, 1'b0, 1'b1, 1'b0);  // RAM read
    step(3'd0, 1'b1, 8'h05, 1'b1, 1'b0, 1'b0, 1'b1);  // register write
    step(3'd0, 1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0);  // register read
    step(3'd1, 1'b1, 8'h03, 1'b1, 1'b0, 1'b1, 1'b1);  // other block
  endtask

  task automatic t_idle_conflict_r10;
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd0, 1'b0, 8'h77, 1'b1, 1'b1, 1'b1, 1'b0);  // fetch beats peripheral read
    step(3'd0, 1'b1, 8'h78, 1'b1, 1'b1, 1'b0, 1'b1);  // fetch with write
    step(3'd1, 1'b0, 8'h79, 1'b1, 1'b1, 1'b1, 1'b0);  // user ROM, read ignored
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset_r11();
    t_latch_r1_r2();
    t_decode_r3();
    t_code_fetch_r4_r5();
    t_ram_r6_r7();
    t_periph_r8_r9();
    t_idle_conflict_r10();
    t_reset_r11();
    step(3'd6, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule